// File: doc/BRIEF.md
# OSD Overlay Pixel Mixer

This block merges a low-rate on-screen-display stream from an external microcontroller into a full-rate 10-bit RGB video pixel path. The microcontroller has one wire each for red, green and blue, plus an overlay enable and a half-intensity control. The block drives horizontal sync, vertical sync and a half-rate pixel clock back to the microcontroller, so that both sides stay in step.

Inside the video clock domain, a phase bit marks the two video pixels that belong to one OSD pixel. Its value is the half-rate clock given to the microcontroller, and it is forced low at every horizontal sync. The five OSD wires are registered once per OSD pixel, on the video edge at which that clock is low. The registered sample is used for the next two output pixels. The block has three selection cases. With the overlay enabled, the 3-bit colour is expanded to a fixed 10-bit-per-channel colour and replaces the video. With the overlay off and half intensity on, the video is halved. With both off, the video passes through unchanged. The result and the syncs appear one video clock after the video and sync inputs.

Top module: `osd_mixer`

## Requirements
- R1: While rst_ni is low, out_r_o, out_g_o and out_b_o are 0, and osd_clk_o, hsync_o and vsync_o are low.
- R2: After any rising edge at which hsync_i was high, osd_clk_o is low. After any rising edge at which hsync_i was low, osd_clk_o is the inverse of its previous value.
- R3: The five OSD inputs are sampled only at a rising edge where osd_clk_o is low. That sample sets the output pixels registered at the following two rising edges, and no others.
- R4: With the overlay enabled and a colour code other than 000 or 111, each channel whose wire is high (osd_r_i is red, osd_g_i is green, osd_b_i is blue) outputs 1023, and each channel whose wire is low outputs 512.
- R5: With the overlay enabled, colour code 000 outputs 0 on all channels and colour code 111 outputs 1023 on all channels.
- R6: With the overlay enabled, the video inputs and osd_half_i have no effect on the output.
- R7: With the overlay off and half intensity on, each output channel equals the corresponding video channel shifted right by one bit.
- R8: With both the overlay and half intensity off, each output channel equals its video channel, and the colour wires have no effect.
- R9: Output pixels reflect the video inputs sampled at the previous rising edge. hsync_o and vsync_o equal hsync_i and vsync_i from the previous rising edge.
- R10: Changes to the OSD inputs at a rising edge where osd_clk_o is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Video pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vid_r_i | input | 10 | Video red channel |
| vid_g_i | input | 10 | Video green channel |
| vid_b_i | input | 10 | Video blue channel |
| hsync_i | input | 1 | Horizontal sync, active high |
| vsync_i | input | 1 | Vertical sync, active high |
| osd_r_i | input | 1 | OSD red wire |
| osd_g_i | input | 1 | OSD green wire |
| osd_b_i | input | 1 | OSD blue wire |
| osd_en_i | input | 1 | OSD overlay enable |
| osd_half_i | input | 1 | Halve video intensity when not overlaid |
| out_r_o | output | 10 | Mixed red channel |
| out_g_o | output | 10 | Mixed green channel |
| out_b_o | output | 10 | Mixed blue channel |
| hsync_o | output | 1 | Delayed horizontal sync, also used by the microcontroller |
| vsync_o | output | 1 | Delayed vertical sync, also used by the microcontroller |
| osd_clk_o | output | 1 | Half-rate pixel clock for the microcontroller |

## Verification
The bench changes the OSD wires in the middle of an OSD pixel. A design that samples on both video edges, or that fails to hold the sample, would show the new value one pixel early and break the two-pixel replication. It asserts horizontal sync while the phase is high and holds it for several cycles. A design that does not restart the phase would shift the microcontroller clock and misalign the pixel pairs. The colour table checks black, white and the mixed codes separately, because a design that treats 000 and 111 like the other codes would output 512 where it should output 0. Dimming is checked on odd and full-scale values, and then with the overlay enabled, to catch wrong rounding and to catch dimming that leaks into overlaid pixels.

// File: rtl/osd_mixer_pkg.sv
package osd_mixer_pkg;
  // code is {red, green, blue}
  typedef struct packed {
    logic       en;
    logic       half;
    logic [2:0] code;
  } osd_smp_t;
endpackage

// File: rtl/osd_phase_gen.sv
module osd_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hsync_i,
  output logic ph_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ph_o <= 1'b0;
    else if (hsync_i) ph_o <= 1'b0;
    else              ph_o <= ~ph_o;
  end
endmodule

// File: rtl/osd_capture.sv
module osd_capture
  import osd_mixer_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     load_i,
  input  osd_smp_t d_i,
  output osd_smp_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= '0;
    else if (load_i) q_o <= d_i;
  end
endmodule

// File: rtl/osd_color_lut.sv
module osd_color_lut #(
  parameter int CW = 10
) (
  input  logic [2:0]         code_i,
  output logic [2:0][CW-1:0] rgb_o
);
  localparam logic [CW-1:0] FULL = '1;
  localparam logic [CW-1:0] MID  = {1'b1, {(CW-1){1'b0}}};

  logic black;
  assign black = (code_i == 3'b000);

  for (genvar c = 0; c < 3; c++) begin : g_ch
    always_comb begin
      if (black)          rgb_o[c] = '0;
      else if (code_i[c]) rgb_o[c] = FULL;
      else                rgb_o[c] = MID;
    end
  end
endmodule

// File: rtl/osd_pixel_sel.sv
module osd_pixel_sel #(
  parameter int CW = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [2:0][CW-1:0] vid_i,
  input  logic [2:0][CW-1:0] osd_rgb_i,
  input  logic               en_i,
  input  logic               half_i,
  input  logic               hsync_i,
  input  logic               vsync_i,
  output logic [2:0][CW-1:0] pix_o,
  output logic               hsync_o,
  output logic               vsync_o
);
  logic [2:0][CW-1:0] pix_d;

  for (genvar c = 0; c < 3; c++) begin : g_ch
    always_comb begin
      if (en_i)        pix_d[c] = osd_rgb_i[c];
      else if (half_i) pix_d[c] = vid_i[c] >> 1;
      else             pix_d[c] = vid_i[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_o   <= '0;
      hsync_o <= 1'b0;
      vsync_o <= 1'b0;
    end else begin
      pix_o   <= pix_d;
      hsync_o <= hsync_i;
      vsync_o <= vsync_i;
    end
  end
endmodule

// File: rtl/osd_mixer.sv
module osd_mixer
  import osd_mixer_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] vid_r_i,
  input  logic [CW-1:0] vid_g_i,
  input  logic [CW-1:0] vid_b_i,
  input  logic          hsync_i,
  input  logic          vsync_i,
  input  logic          osd_r_i,
  input  logic          osd_g_i,
  input  logic          osd_b_i,
  input  logic          osd_en_i,
  input  logic          osd_half_i,
  output logic [CW-1:0] out_r_o,
  output logic [CW-1:0] out_g_o,
  output logic [CW-1:0] out_b_o,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          osd_clk_o
);
  logic               ph;
  osd_smp_t           osd_d, osd_q;
  logic [2:0][CW-1:0] osd_rgb, vid, pix;

  assign osd_d = '{en: osd_en_i, half: osd_half_i, code: {osd_r_i, osd_g_i, osd_b_i}};
  assign vid   = {vid_r_i, vid_g_i, vid_b_i};

  osd_phase_gen u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hsync_i (hsync_i),
    .ph_o    (ph)
  );

  // sample on the rising edge of the half-rate clock
  osd_capture u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (~ph),
    .d_i    (osd_d),
    .q_o    (osd_q)
  );

  osd_color_lut #(.CW(CW)) u_lut (
    .code_i (osd_q.code),
    .rgb_o  (osd_rgb)
  );

  osd_pixel_sel #(.CW(CW)) u_sel (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .vid_i     (vid),
    .osd_rgb_i (osd_rgb),
    .en_i      (osd_q.en),
    .half_i    (osd_q.half),
    .hsync_i   (hsync_i),
    .vsync_i   (vsync_i),
    .pix_o     (pix),
    .hsync_o   (hsync_o),
    .vsync_o   (vsync_o)
  );

  assign out_r_o   = pix[2];
  assign out_g_o   = pix[1];
  assign out_b_o   = pix[0];
  assign osd_clk_o = ph;
endmodule

// File: rtl/osd_mixer_chk.sv
module osd_mixer_chk
  import osd_mixer_pkg::*;
#(
  parameter int CW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          hsync_i,
  input logic          vsync_i,
  input logic          hsync_o,
  input logic          vsync_o,
  input logic          osd_clk_o,
  input osd_smp_t      osd_q,
  input logic [CW-1:0] out_r_o,
  input logic [CW-1:0] out_g_o,
  input logic [CW-1:0] out_b_o
);
  localparam logic [CW-1:0] FULL = '1;
  localparam logic [CW-1:0] MID  = {1'b1, {(CW-1){1'b0}}};

  // R2
  osd_clk_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_i |=> (osd_clk_o != $past(osd_clk_o)));
  // R2
  osd_clk_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_i |=> !osd_clk_o);
  // R9
  hsync_dly_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_i |=> hsync_o);
  // R9
  hsync_dly_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_i |=> !hsync_o);
  // R9
  vsync_dly_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_i |=> vsync_o);
  // R10
  osd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osd_clk_o |=> $stable(osd_q));
  // R5
  osd_white_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osd_q.en && osd_q.code == 3'b111) |=> (out_r_o == FULL && out_g_o == FULL && out_b_o == FULL));
  // R4
  osd_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (osd_q.en && osd_q.code != 3'b000) |=> ((out_g_o == FULL || out_g_o == MID) && (out_r_o == FULL || out_r_o == MID)));
  // R7
  dim_msb_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osd_q.en && osd_q.half) |=> !(out_r_o[CW-1] || out_g_o[CW-1] || out_b_o[CW-1]));
endmodule

bind osd_mixer osd_mixer_chk #(.CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hsync_i   (hsync_i),
  .vsync_i   (vsync_i),
  .hsync_o   (hsync_o),
  .vsync_o   (vsync_o),
  .osd_clk_o (osd_clk_o),
  .osd_q     (osd_q),
  .out_r_o   (out_r_o),
  .out_g_o   (out_g_o),
  .out_b_o   (out_b_o)
);

// File: tb/osd_mixer_bench.sv
module osd_mixer_bench;
  localparam int PERIOD = 10;
  localparam int CW     = 10;
  localparam int NV     = 9;

  typedef struct packed {
    logic [CW-1:0] r, g, b;
    logic [2:0]    code;
    logic          en, half;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{r: 300, g: 600, b: 900,  code: 3'b000, en: 1, half: 0},
    '{r: 300, g: 600, b: 900,  code: 3'b111, en: 1, half: 0},
    '{r: 10,  g: 20,  b: 30,   code: 3'b100, en: 1, half: 0},
    '{r: 10,  g: 20,  b: 30,   code: 3'b011, en: 1, half: 0},
    '{r: 300, g: 601, b: 1023, code: 3'b000, en: 0, half: 1},
    '{r: 123, g: 456, b: 789,  code: 3'b000, en: 0, half: 0},
    '{r: 999, g: 5,   b: 77,   code: 3'b010, en: 1, half: 1},
    '{r: 44,  g: 55,  b: 66,   code: 3'b111, en: 0, half: 0},
    '{r: 1,   g: 0,   b: 2,    code: 3'b101, en: 0, half: 1}
  };

  logic          clk_i = 0, rst_ni = 0;
  logic [CW-1:0] vid_r_i = 0, vid_g_i = 0, vid_b_i = 0;
  logic          hsync_i = 0, vsync_i = 0;
  logic          osd_r_i = 0, osd_g_i = 0, osd_b_i = 0, osd_en_i = 0, osd_half_i = 0;
  logic [CW-1:0] out_r_o, out_g_o, out_b_o;
  logic          hsync_o, vsync_o, osd_clk_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk_i = ~clk_i;

  osd_mixer #(.CW(CW)) u_osd_mixer (
    .clk_i, .rst_ni, .vid_r_i, .vid_g_i, .vid_b_i, .hsync_i, .vsync_i,
    .osd_r_i, .osd_g_i, .osd_b_i, .osd_en_i, .osd_half_i,
    .out_r_o, .out_g_o, .out_b_o, .hsync_o, .vsync_o, .osd_clk_o
  );

  task automatic chk(string req, logic [3*CW-1:0] act, logic [3*CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3*CW-1:0] exp_pix(vec_t v);
    logic [CW-1:0] full, mid;
    full = '1;
    mid  = 1 << (CW-1);
    if (v.en) begin
      if (v.code == 3'b000) return '0;
      return {v.code[2] ? full : mid, v.code[1] ? full : mid, v.code[0] ? full : mid};
    end
    if (v.half) return {v.r >> 1, v.g >> 1, v.b >> 1};
    return {v.r, v.g, v.b};
  endfunction

  function automatic string tag(vec_t v);
    if (v.en && (v.code == 3'b000 || v.code == 3'b111)) return "R5";
    if (v.en && v.half) return "R6";
    if (v.en) return "R4";
    if (v.half) return "R7";
    return "R8";
  endfunction

  task automatic apply(vec_t v);
    {vid_r_i, vid_g_i, vid_b_i} = {v.r, v.g, v.b};
    {osd_r_i, osd_g_i, osd_b_i} = v.code;
    osd_en_i   = v.en;
    osd_half_i = v.half;
  endtask

  function automatic logic [3*CW-1:0] outs();
    return {out_r_o, out_g_o, out_b_o};
  endfunction

  initial begin
    #(PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    vec_t va, vb;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 pixels", outs(), '0);
    chk("R1 osd_clk", {29'd0, osd_clk_o}, '0);
    chk("R1 syncs", {28'd0, hsync_o, vsync_o}, '0);
    rst_ni = 1;

    // R2 / R9 sync delay and phase restart
    @(negedge clk_i); hsync_i = 1; vsync_i = 1;
    @(negedge clk_i);
    chk("R9 syncs high", {28'd0, hsync_o, vsync_o}, 30'd3);
    chk("R2 clk low after hsync", {29'd0, osd_clk_o}, '0);
    hsync_i = 0; vsync_i = 0;
    @(negedge clk_i);
    chk("R9 syncs low", {28'd0, hsync_o, vsync_o}, '0);
    chk("R2 toggle high", {29'd0, osd_clk_o}, 30'd1);
    @(negedge clk_i);
    chk("R2 toggle low", {29'd0, osd_clk_o}, '0);
    @(negedge clk_i);
    chk("R2 toggle high again", {29'd0, osd_clk_o}, 30'd1);
    hsync_i = 1;
    @(negedge clk_i);
    chk("R2 restart from high", {29'd0, osd_clk_o}, '0);
    @(negedge clk_i);
    chk("R2 held low in long hsync", {29'd0, osd_clk_o}, '0);
    hsync_i = 0;

    // table walk: one OSD pixel per vector, first replica checked
    @(negedge clk_i); hsync_i = 1;
    for (int k = 0; k < NV; k++) begin
      @(negedge clk_i);
      if (k == 0) hsync_i = 0;
      if (k > 0) chk({tag(VECS[k-1]), " R9 vector"}, outs(), exp_pix(VECS[k-1]));
      apply(VECS[k]);
      @(negedge clk_i);
    end
    @(negedge clk_i);
    chk({tag(VECS[NV-1]), " R9 vector"}, outs(), exp_pix(VECS[NV-1]));

    // R3 / R10 replication and mid-pixel change
    va = '{r: 400, g: 200, b: 100, code: 3'b101, en: 1, half: 0};
    vb = '{r: 400, g: 200, b: 100, code: 3'b010, en: 0, half: 1};
    @(negedge clk_i); hsync_i = 1;
    @(negedge clk_i); hsync_i = 0; apply(va);
    @(negedge clk_i); apply(vb);
    @(negedge clk_i);
    chk("R3 first replica", outs(), exp_pix(va));
    @(negedge clk_i);
    chk("R10 second replica ignores mid change", outs(), exp_pix(va));
    @(negedge clk_i);
    chk("R3 next sample takes over", outs(), exp_pix(vb));

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule